// File: doc/BRIEF.md
# Write-through data cache with store buffer

This block is a direct-mapped data cache placed between a processor load/store port and a simple request/response memory port. Loads that hit return one 8-byte word from the selected line. Loads that miss fetch the whole 32-byte line. The word the processor asked for is requested first and handed back as soon as it arrives, and the rest of the line fills in wrap-around order behind it.

Every store goes through to memory by way of a small FIFO of pending writes, which drains in the background whenever the memory port is free. A store that hits also updates the cached word. A store that misses leaves the cache untouched. When a load misses, the block address is compared against every pending write. With no match, the line fetch goes to memory ahead of the queued writes. With a match, the FIFO first drains up to and including the youngest matching entry.

The memory port moves one transfer on every cycle in which `mem_req` and `mem_gnt` are both high. The requester may change or withdraw a request that has not been granted. A granted read is answered by one `mem_rvalid` beat per word of the line.

Top module: `wtc_cache`

## Requirements
- R1: After reset, `cpu_ready` is high, `mem_req` is low, `cpu_rvalid` is low and every line is invalid, so the first load to any address misses.
- R2: A load hits when the indexed line is valid and its stored tag equals the address tag. A hit raises `cpu_rvalid` for one cycle, one cycle after the lookup cycle, which is the second rising edge after acceptance. A hit issues no memory read.
- R3: Address bits [4:3] select which 8-byte word of the 32-byte line is returned. Bits [2:0] have no effect on the result.
- R4: A load miss issues exactly one memory read (`mem_we` low). Its address is the block address followed by the requested word index, with bits [2:0] zero. Memory returns four beats, starting at that word and wrapping within the line. All four beats are written into the line, and the line then becomes valid with the new tag.
- R5: On a miss, `cpu_rvalid` rises with the requested word in the cycle after the first refill beat is taken. `cpu_ready` stays low until the last beat has been written.
- R6: Every accepted store appears on the memory port as a write (`mem_we` high) with the same address and data. Stores appear in the order they were accepted.
- R7: A store that hits updates the cached word, so a later load of that word hits and returns the stored data. A store that misses allocates no line, so a later load of that block misses.
- R8: The store FIFO holds 4 entries. While 4 stores are pending, `cpu_ready` is low whenever `cpu_we` is high, and the store is accepted once an entry has drained.
- R9: A load miss whose block matches no pending store issues its memory read and completes while those stores are still pending.
- R10: A load miss whose block matches a pending store issues no memory read until every store up to the youngest matching one has drained. The word returned then reflects that store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W (32) | Byte address |
| cpu_wdata | input | WORD_W (64) | Store data |
| cpu_ready | output | 1 | Request accepted on this cycle if `cpu_req` is high |
| cpu_rvalid | output | 1 | Load data valid, one-cycle pulse |
| cpu_rdata | output | WORD_W (64) | Load data |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write one word, 0 = read one line |
| mem_addr | output | ADDR_W (32) | Memory byte address |
| mem_wdata | output | WORD_W (64) | Memory write data |
| mem_gnt | input | 1 | Memory takes the request this cycle |
| mem_rvalid | input | 1 | Refill beat valid |
| mem_rdata | input | WORD_W (64) | Refill beat data |

## Verification
The bench builds the cache with a 10-bit address and a 2-bit index. That gives four lines, a 3-bit tag and a 128-word memory, so every word can be read in one sweep. The sweep rotates the critical word from block to block and sets nonzero byte offsets, and it evicts lines constantly, which exercises every wrap start and every tag replacement. The bench can withhold the write grant. That keeps the 4-entry FIFO full, and it leaves stores pending while a load that matches them, or a load that does not, misses.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOKUP,
    S_DRAIN,
    S_RDREQ,
    S_REFILL
  } wtc_state_e;
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
  parameter int IDX_W = 8,
  parameter int TAG_W = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_mem [LINES];
  logic [LINES-1:0] valid_q;

  // tag array: synchronous read, suitable for block RAM
  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
    rd_tag <= tag_mem[rd_idx];
  end

  // valid bits live in flops so reset can clear them at once
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en) valid_q[wr_idx] <= 1'b1;
      rd_valid <= valid_q[rd_idx];
    end
  end
endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
  parameter int AW = 10,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  localparam int ENTRIES = 1 << AW;

  logic [DW-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/wtc_wbuf.sv
module wtc_wbuf #(
  parameter int DEPTH = 4,
  parameter int AW    = 29,
  parameter int DW    = 64,
  parameter int BLK_W = 27
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [AW-1:0]    push_addr,
  input  logic [DW-1:0]    push_data,
  input  logic             pop,
  output logic [AW-1:0]    head_addr,
  output logic [DW-1:0]    head_data,
  output logic             empty,
  output logic             full,
  input  logic [BLK_W-1:0] chk_blk,
  output logic             conflict
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] used_q;
  logic [DEPTH-1:0] match;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count_q;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_ptr] <= push_addr;
      data_q[wr_ptr] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
      used_q  <= '0;
    end else begin
      if (push) begin
        wr_ptr         <= step(wr_ptr);
        used_q[wr_ptr] <= 1'b1;
      end
      if (pop) begin
        rd_ptr         <= step(rd_ptr);
        used_q[rd_ptr] <= 1'b0;
      end
      case ({push, pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  // one block-address comparator per slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = used_q[i] && (addr_q[i][AW-1 -: BLK_W] == chk_blk);
  end

  assign conflict  = |match;
  assign head_addr = addr_q[rd_ptr];
  assign head_data = data_q[rd_ptr];
  assign empty     = (count_q == '0);
  assign full      = (count_q == CNT_W'(DEPTH));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst) push |-> !full)
    else $error("store pushed into a full buffer");
  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst) pop |-> !empty)
    else $error("drain from an empty buffer");
endmodule

// File: rtl/wtc_cache.sv
module wtc_cache
  import wtc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 8,
  parameter int OFF_W    = 5,
  parameter int WORD_W   = 64,
  parameter int WB_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_rvalid,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata
);
  localparam int BYTE_W  = $clog2(WORD_W / 8);
  localparam int SEL_W   = OFF_W - BYTE_W;
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
  localparam int WADDR_W = ADDR_W - BYTE_W;
  localparam int BLK_W   = ADDR_W - OFF_W;
  localparam int DA_W    = IDX_W + SEL_W;

  wtc_state_e state;

  logic [WADDR_W-1:0] req_word_q;
  logic               req_we_q;
  logic [WORD_W-1:0]  req_wdata_q;
  logic [SEL_W-1:0]   beat_q;
  logic               rvalid_q;
  logic [WORD_W-1:0]  rdata_q;

  logic [TAG_W-1:0]   q_tag, st_tag;
  logic [IDX_W-1:0]   q_idx;
  logic [SEL_W-1:0]   q_sel, fill_sel;
  logic [BLK_W-1:0]   q_blk;
  logic               st_valid, hit, cpu_acc, fill_beat, fill_last;
  logic [WORD_W-1:0]  rd_word;
  logic               d_we;
  logic [DA_W-1:0]    d_waddr;
  logic [WORD_W-1:0]  d_wdata;
  logic               wb_push, wb_pop, wb_empty, wb_full, wb_conflict, drain_ok, rd_port;
  logic [WADDR_W-1:0] wb_head_addr;
  logic [WORD_W-1:0]  wb_head_data;
  logic               unused_byte_bits;

  assign unused_byte_bits = ^cpu_addr[BYTE_W-1:0];

  assign q_sel     = req_word_q[SEL_W-1:0];
  assign q_idx     = req_word_q[SEL_W +: IDX_W];
  assign q_tag     = req_word_q[WADDR_W-1 -: TAG_W];
  assign q_blk     = req_word_q[WADDR_W-1 -: BLK_W];
  assign fill_sel  = q_sel + beat_q;
  assign fill_beat = (state == S_REFILL) && mem_rvalid;
  assign fill_last = fill_beat && (beat_q == '1);

  assign cpu_ready = (state == S_IDLE) && !(cpu_we && wb_full);
  assign cpu_acc   = cpu_req && cpu_ready;
  assign hit       = st_valid && (st_tag == q_tag);

  wtc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (cpu_addr[OFF_W +: IDX_W]),
    .wr_en    (fill_last),
    .wr_idx   (q_idx),
    .wr_tag   (q_tag),
    .rd_tag   (st_tag),
    .rd_valid (st_valid)
  );

  assign d_we    = (state == S_LOOKUP && req_we_q && hit) || fill_beat;
  assign d_waddr = {q_idx, (state == S_REFILL) ? fill_sel : q_sel};
  assign d_wdata = (state == S_REFILL) ? mem_rdata : req_wdata_q;

  wtc_data_store #(.AW(DA_W), .DW(WORD_W)) u_data (
    .clk     (clk),
    .rd_addr (cpu_addr[BYTE_W +: DA_W]),
    .rd_data (rd_word),
    .wr_en   (d_we),
    .wr_addr (d_waddr),
    .wr_data (d_wdata)
  );

  // memory port: the line fetch has priority, stores drain otherwise
  assign rd_port  = (state == S_RDREQ);
  assign drain_ok = (state != S_RDREQ) && (state != S_REFILL);
  assign wb_push  = (state == S_LOOKUP) && req_we_q;
  assign wb_pop   = drain_ok && !wb_empty && mem_gnt;

  assign mem_req   = rd_port || (drain_ok && !wb_empty);
  assign mem_we    = !rd_port;
  assign mem_addr  = rd_port ? {req_word_q, {BYTE_W{1'b0}}} : {wb_head_addr, {BYTE_W{1'b0}}};
  assign mem_wdata = wb_head_data;

  wtc_wbuf #(.DEPTH(WB_DEPTH), .AW(WADDR_W), .DW(WORD_W), .BLK_W(BLK_W)) u_wbuf (
    .clk       (clk),
    .rst       (rst),
    .push      (wb_push),
    .push_addr (req_word_q),
    .push_data (req_wdata_q),
    .pop       (wb_pop),
    .head_addr (wb_head_addr),
    .head_data (wb_head_data),
    .empty     (wb_empty),
    .full      (wb_full),
    .chk_blk   (q_blk),
    .conflict  (wb_conflict)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      rvalid_q <= 1'b0;
      beat_q   <= '0;
    end else begin
      rvalid_q <= 1'b0;
      case (state)
        S_IDLE:   if (cpu_acc) state <= S_LOOKUP;
        S_LOOKUP: begin
          if (req_we_q) state <= S_IDLE;
          else if (hit) begin
            state    <= S_IDLE;
            rvalid_q <= 1'b1;
          end
          else if (wb_conflict) state <= S_DRAIN;
          else state <= S_RDREQ;
        end
        S_DRAIN:  if (!wb_conflict) state <= S_RDREQ;
        S_RDREQ:  if (mem_gnt) begin
          state  <= S_REFILL;
          beat_q <= '0;
        end
        S_REFILL: if (mem_rvalid) begin
          beat_q <= beat_q + 1'b1;
          if (beat_q == '0) rvalid_q <= 1'b1;
          if (fill_last) state <= S_IDLE;
        end
        default:  state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (cpu_acc) begin
      req_word_q  <= cpu_addr[ADDR_W-1:BYTE_W];
      req_we_q    <= cpu_we;
      req_wdata_q <= cpu_wdata;
    end
    if (state == S_LOOKUP && !req_we_q && hit) rdata_q <= rd_word;
    else if (fill_beat && beat_q == '0) rdata_q <= mem_rdata;
  end

  assign cpu_rvalid = rvalid_q;
  assign cpu_rdata  = rdata_q;

  // R10
  rd_no_conflict_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> !wb_conflict)
    else $error("line fetch issued over a matching pending store");
  // R2
  hit_no_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_LOOKUP && !req_we_q && hit) |=> !(mem_req && !mem_we))
    else $error("hit followed by a line fetch");
  // R5
  crit_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_beat && beat_q == '0) |=> (cpu_rvalid && cpu_rdata == $past(mem_rdata)))
    else $error("critical word not forwarded");
  // R4
  beat_in_refill_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rvalid |-> (state == S_REFILL))
    else $error("refill beat outside a refill");
endmodule

// File: tb/wtc_cache_bench.sv
module wtc_cache_bench;
  localparam int AW  = 10;
  localparam int DW  = 64;
  localparam int NW  = 128;
  localparam int WPB = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_ready, cpu_rvalid;
  logic [DW-1:0] cpu_rdata;
  logic          mem_req, mem_we, mem_gnt;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_rvalid;
  logic [DW-1:0] mem_rdata;
  logic          wr_en = 1'b1;

  always #2 clk = ~clk;

  assign mem_gnt = mem_we ? wr_en : 1'b1;

  wtc_cache #(.ADDR_W(AW), .IDX_W(2), .OFF_W(5), .WORD_W(DW), .WB_DEPTH(4)) u_wtc_cache (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  function automatic logic [DW-1:0] pat(input int i);
    return {32'hC0DE_0000 + 32'(i), 32'h5A5A_0000 ^ 32'(i * 7)};
  endfunction

  // memory model and write-order monitor
  logic [DW-1:0] memw [NW];
  logic [AW-1:0] exp_a [64];
  logic [DW-1:0] exp_d [64];
  int            exp_tail = 0;
  int            exp_head, rd_count, beats_taken, beat_left, lat, mon_checks, mon_fails;
  logic [6:0]    rd_word;
  logic [AW-1:0] rd_addr_last;

  always @(posedge clk) begin
    if (rst) begin
      rd_count <= 0; beats_taken <= 0; beat_left <= 0; lat <= 0;
      mem_rvalid <= 1'b0; mem_rdata <= '0; exp_head <= 0;
      mon_checks <= 0; mon_fails <= 0; rd_word <= '0; rd_addr_last <= '0;
      for (int i = 0; i < NW; i++) memw[i] <= pat(i);
    end else begin
      if (mem_rvalid) beats_taken <= beats_taken + 1;
      mem_rvalid <= 1'b0;
      if (mem_req && mem_gnt) begin
        if (mem_we) begin
          memw[mem_addr[9:3]] <= mem_wdata;
          mon_checks <= mon_checks + 1;
          if (mem_addr != exp_a[exp_head] || mem_wdata != exp_d[exp_head]) begin
            mon_fails <= mon_fails + 1;
            $display("FAIL R6 write order: actual %h/%h expected %h/%h",
                     mem_addr, mem_wdata, exp_a[exp_head], exp_d[exp_head]);
          end
          exp_head <= (exp_head + 1) % 64;
        end else begin
          rd_count <= rd_count + 1;
          rd_addr_last <= mem_addr;
          rd_word <= mem_addr[9:3];
          lat <= 2;
          beat_left <= WPB;
        end
      end else if (beat_left > 0) begin
        if (lat > 0) lat <= lat - 1;
        else begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= memw[rd_word];
          rd_word    <= {rd_word[6:2], rd_word[1:0] + 2'd1};
          beat_left  <= beat_left - 1;
        end
      end
    end
  end

  logic [DW-1:0] refm [NW];
  int n_checks = 0, n_fails = 0;
  int rc0, bt0, waited, bdelta;
  bit got, rdy_at;
  logic [DW-1:0] rdat;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic start_read(input int w, input int boff);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = AW'(w * 8 + boff);
    #1;
    while (!cpu_ready) begin @(negedge clk); #1; end
    rc0 = rd_count; bt0 = beats_taken;
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic wait_read();
    got = 1'b0; waited = 0;
    for (int k = 0; k < 300 && !got; k++) begin
      @(negedge clk);
      waited++;
      if (cpu_rvalid) begin
        got = 1'b1; rdat = cpu_rdata; rdy_at = cpu_ready; bdelta = beats_taken - bt0;
      end
    end
  endtask

  task automatic cpu_write(input int w, input logic [DW-1:0] d);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = AW'(w * 8); cpu_wdata = d;
    #1;
    while (!cpu_ready) begin @(negedge clk); #1; end
    exp_a[exp_tail] = AW'(w * 8); exp_d[exp_tail] = d; exp_tail = (exp_tail + 1) % 64;
    refm[w] = d;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic drain_wait();
    for (int k = 0; k < 200 && exp_head != exp_tail; k++) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NW; i++) refm[i] = pat(i);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    // R1 reset state
    chk(cpu_ready == 1'b1, "R1 ready after reset", 64'(cpu_ready), 64'd1);
    chk(mem_req == 1'b0, "R1 no memory request after reset", 64'(mem_req), 64'd0);
    chk(cpu_rvalid == 1'b0, "R1 no load data after reset", 64'(cpu_rvalid), 64'd0);

    // sweep of every word, rotating critical word; R1 R2 R3 R4 R5
    for (int b = 0; b < 32; b++) begin
      for (int j = 0; j < WPB; j++) begin
        int w;
        w = b * WPB + ((j + b) % WPB);
        start_read(w, w % 8);
        wait_read();
        chk(got, "R2 load completes", 64'(got), 64'd1);
        chk(rdat == refm[w], (j == 0) ? "R5 critical word data" : "R3 word select on hit",
            rdat, refm[w]);
        if (j == 0) begin
          chk(rd_count - rc0 == 1, (b == 0) ? "R1 first load misses" : "R4 one fetch per miss",
              64'(rd_count - rc0), 64'd1);
          chk(rd_addr_last == AW'(w * 8), "R4 fetch address", 64'(rd_addr_last), 64'(w * 8));
          chk(bdelta == 1, "R5 forwarded after first beat", 64'(bdelta), 64'd1);
          chk(rdy_at == 1'b0, "R5 busy until line full", 64'(rdy_at), 64'd0);
        end else begin
          chk(rd_count == rc0, "R2 hit issues no fetch", 64'(rd_count - rc0), 64'd0);
          chk(waited == 1, "R2 hit latency", 64'(waited), 64'd1);
        end
      end
    end

    // R7 write hit on cached word 113 (block 28)
    cpu_write(113, 64'h1111_2222_3333_4444);
    start_read(113, 0); wait_read();
    chk(rdat == 64'h1111_2222_3333_4444, "R7 write hit updates line", rdat, 64'h1111_2222_3333_4444);
    chk(rd_count == rc0, "R7 write hit then load hits", 64'(rd_count - rc0), 64'd0);
    // R7 write miss on block 2 (line holds block 30)
    cpu_write(8, 64'hABCD_0000_0000_0008);
    drain_wait();
    start_read(8, 0); wait_read();
    chk(rd_count - rc0 == 1, "R7 write miss allocates nothing", 64'(rd_count - rc0), 64'd1);
    chk(rdat == 64'hABCD_0000_0000_0008, "R6 written through", rdat, 64'hABCD_0000_0000_0008);

    // R8 buffer full stalls a store
    wr_en = 1'b0;
    for (int k = 0; k < 4; k++) cpu_write(40 + 4 * k, 64'hF0F0_0000_0000_0000 + 64'(k));
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = AW'(56 * 8); cpu_wdata = 64'hF0F0_0000_0000_0004;
    #1;
    chk(cpu_ready == 1'b0, "R8 fifth store stalled", 64'(cpu_ready), 64'd0);
    repeat (5) @(negedge clk);
    #1;
    chk(cpu_ready == 1'b0, "R8 stall holds without drain", 64'(cpu_ready), 64'd0);
    wr_en = 1'b1;
    got = 1'b0;
    for (int k = 0; k < 50 && !got; k++) begin
      @(negedge clk); #1;
      if (cpu_ready) got = 1'b1;
    end
    chk(got, "R8 store accepted after drain", 64'(got), 64'd1);
    exp_a[exp_tail] = AW'(56 * 8); exp_d[exp_tail] = 64'hF0F0_0000_0000_0004;
    exp_tail = (exp_tail + 1) % 64; refm[56] = 64'hF0F0_0000_0000_0004;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
    drain_wait();

    // R9 read bypasses a non-matching pending store
    wr_en = 1'b0;
    cpu_write(64, 64'h9999_0000_0000_0040);
    start_read(7, 3); wait_read();
    chk(got, "R9 miss completes with store pending", 64'(got), 64'd1);
    chk(rdat == refm[7], "R9 bypass data", rdat, refm[7]);
    chk(rd_count - rc0 == 1, "R9 fetch issued", 64'(rd_count - rc0), 64'd1);
    chk(exp_head != exp_tail, "R9 store still pending", 64'(exp_tail - exp_head), 64'd1);
    wr_en = 1'b1;
    drain_wait();

    // R10 read waits for a matching pending store
    wr_en = 1'b0;
    cpu_write(22, 64'h2222_0000_0000_0016);
    cpu_write(100, 64'h2222_0000_0000_0064);
    start_read(22, 5);
    got = 1'b0;
    repeat (30) begin
      @(negedge clk);
      if (cpu_rvalid) got = 1'b1;
    end
    chk(!got && rd_count == rc0, "R10 fetch held behind matching store",
        64'(rd_count - rc0), 64'd0);
    wr_en = 1'b1;
    wait_read();
    chk(got && rdat == 64'h2222_0000_0000_0016, "R10 data reflects store", rdat,
        64'h2222_0000_0000_0016);
    start_read(21, 0); wait_read();
    chk(rdat == refm[21] && rd_count == rc0, "R4 line filled after drained miss", rdat, refm[21]);

    drain_wait();
    chk(exp_head == exp_tail, "R6 every store reached memory", 64'(exp_tail - exp_head), 64'd0);
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_checks + mon_checks, n_fails + mon_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_checks + mon_checks + 1, n_fails + mon_fails + 1);
    $finish;
  end
endmodule